// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

A fully associative buffer of page translations for a memory management path. Each slot stores a virtual page number, an address space identifier, a global flag, a physical page number, two 4-bit permission masks (read and write, one bit per privilege mode: kernel bit 0, executive bit 1, supervisor bit 2, user bit 3) and two trap-on-access flags (read and write). The masks and trap flags are stored and returned unchanged. The buffer does not interpret them.

A lookup is purely combinational over the stored state. It returns a hit flag, the slot index, the stored fields and the physical address. Pages are 8 KB, so the low 13 address bits pass through as the offset. Refill software or a walker writes new translations through the insert port into the slot chosen by a round-robin pointer. The slot at that pointer can also be read back through an indexed-read port, which can step the pointer. Three invalidation commands are provided: drop everything, drop all non-global slots, or drop the slots that translate one page in one address space.

Top module: `asn_xlate_buf`

## Requirements
- R1: `lk_hit` is 1 exactly when some slot is valid, its stored page number equals `lk_va[VA_W-1:13]`, and either its global flag is 1 or its stored identifier equals `lk_asn`. `lk_idx` gives the lowest such slot.
- R2: An insert that is not blocked by a flush writes all `ins_*` fields into the slot at the pointer (`rd_idx`) and marks it valid, whatever that slot held before.
- R3: The pointer steps by exactly one on a clock edge that has an unblocked insert, or `rd_adv`, or both. It wraps from N-1 to 0.
- R4: `fl_all` zeroes every field of every slot, so all slots are invalid, and it sets the pointer to 0.
- R5: `fl_proc` invalidates every slot whose global flag is 0 and leaves global slots valid and unchanged.
- R6: `fl_addr` invalidates each valid slot whose page number equals `fl_vpn` and that is global or holds `fl_asn`. Other slots keep their state.
- R7: The `rd_*` outputs show the slot at the pointer combinationally. The pointer holds when neither `rd_adv` nor an unblocked insert is present.
- R8: On a hit, `lk_pa` equals {stored physical page number, `lk_va[12:0]`}.
- R9: Any flush command blocks an insert in the same cycle: nothing is written, and the insert does not step the pointer. A lookup in the cycle of a flush reports the state before the flush.
- R10: After reset every slot is invalid, the pointer is 0, and every lookup misses.
- R11: On a hit, `lk_ppn`, `lk_rd_en`, `lk_wr_en`, `lk_rd_trap`, `lk_wr_trap` and `lk_glob` carry the matching slot's fields. On a miss, these outputs, `lk_idx` and `lk_pa` are all 0.
- R12: When several flush commands are raised together, `fl_all` overrides `fl_proc`, which overrides `fl_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asn | input | ASN_W | Lookup address space identifier |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_idx | output | IDX_W | Matching slot index |
| lk_glob | output | 1 | Global flag of match |
| lk_ppn | output | PPN_W | Physical page number of match |
| lk_rd_en | output | MODE_W | Read enable mask of match |
| lk_wr_en | output | MODE_W | Write enable mask of match |
| lk_rd_trap | output | 1 | Trap-on-read flag of match |
| lk_wr_trap | output | 1 | Trap-on-write flag of match |
| lk_pa | output | PPN_W+13 | Translated physical address |
| ins_en | input | 1 | Insert request |
| ins_vpn | input | VPN_W | Page number to store |
| ins_asn | input | ASN_W | Identifier to store |
| ins_glob | input | 1 | Global flag to store |
| ins_ppn | input | PPN_W | Physical page to store |
| ins_rd_en | input | MODE_W | Read mask to store |
| ins_wr_en | input | MODE_W | Write mask to store |
| ins_rd_trap | input | 1 | Trap-on-read to store |
| ins_wr_trap | input | 1 | Trap-on-write to store |
| rd_adv | input | 1 | Step the pointer |
| rd_idx | output | IDX_W | Pointer value |
| rd_valid | output | 1 | Valid bit of slot at pointer |
| rd_vpn | output | VPN_W | Page number at pointer |
| rd_asn | output | ASN_W | Identifier at pointer |
| rd_glob | output | 1 | Global flag at pointer |
| rd_ppn | output | PPN_W | Physical page at pointer |
| rd_rd_en | output | MODE_W | Read mask at pointer |
| rd_wr_en | output | MODE_W | Write mask at pointer |
| rd_rd_trap | output | 1 | Trap-on-read at pointer |
| rd_wr_trap | output | 1 | Trap-on-write at pointer |
| fl_all | input | 1 | Invalidate all slots |
| fl_proc | input | 1 | Invalidate non-global slots |
| fl_addr | input | 1 | Invalidate one page |
| fl_vpn | input | VPN_W | Page number for `fl_addr` |
| fl_asn | input | ASN_W | Identifier for `fl_addr` |

## Verification
The bench targets the following corner cases, each with the failure it exposes:

- **Global slot probed with a foreign identifier.** A design that always compares identifiers misses here.
- **Page flush carrying the wrong identifier.** A design that ignores the identifier on flush wrongly drops the slot.
- **Process flush.** A design that clears global slots loses kernel-wide mappings.
- **Insert raised together with a flush.** A design that lets the insert through writes a slot or steps the pointer.
- **Pointer wrap after N inserts.** An off-by-one pointer shows a wrong `rd_idx`.
- **Insert and `rd_adv` in the same cycle.** A design that steps twice shows a wrong `rd_idx`.

Random traffic over a small page and identifier space adds many same-page, different-space slots. It checks every lookup and readback output against a reference model each cycle.

// File: rtl/xlb_pkg.sv
package xlb_pkg;

   // Invalidate command after priority resolution.
   typedef enum logic [1:0] {
      FL_NONE = 2'd0,
      FL_ADDR = 2'd1,
      FL_PROC = 2'd2,
      FL_ALL  = 2'd3
   } xlb_flush_e;

   // Resolve simultaneous invalidate requests: all > proc > addr.
   function automatic xlb_flush_e xlb_flush_pick(input logic f_all,
                                                  input logic f_proc,
                                                  input logic f_addr);
      if (f_all)       return FL_ALL;
      else if (f_proc) return FL_PROC;
      else if (f_addr) return FL_ADDR;
      else             return FL_NONE;
   endfunction

endpackage

// File: rtl/xlb_match.sv
// Per-slot compare: page number equal, and global or same identifier.
module xlb_match #(
   parameter int N     = 8,
   parameter int VPN_W = 19,
   parameter int ASN_W = 8
) (
   input  logic [N-1:0]            valid,
   input  logic [N-1:0]            glob,
   input  logic [N-1:0][VPN_W-1:0] tag,
   input  logic [N-1:0][ASN_W-1:0] asn,
   input  logic [VPN_W-1:0]        q_vpn,
   input  logic [ASN_W-1:0]        q_asn,
   output logic [N-1:0]            match
);
   for (genvar g = 0; g < N; g++) begin : g_slot
      logic tag_eq;
      logic asn_ok;
      assign tag_eq   = (tag[g] == q_vpn);
      assign asn_ok   = glob[g] | (asn[g] == q_asn);
      assign match[g] = valid[g] & tag_eq & asn_ok;
   end
endmodule

// File: rtl/xlb_prio.sv
// Lowest-index-wins encoder.
module xlb_prio #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = |req;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/xlb_rr_ptr.sv
// Round-robin replacement pointer with a synchronous clear.
module xlb_rr_ptr #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   output logic [IDX_W-1:0] ptr
);
   localparam bit POW2 = ((N & (N - 1)) == 0);

   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] ptr_inc;

   if (POW2) begin : g_pow2
      // Natural overflow of the counter is the wrap.
      assign ptr_inc = ptr_q + 1'b1;
   end else begin : g_cmp
      assign ptr_inc = (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr_q <= '0;
      else if (clear) ptr_q <= '0;
      else if (step)  ptr_q <= ptr_inc;
   end

   assign ptr = ptr_q;
endmodule

// File: rtl/asn_xlate_buf.sv
module asn_xlate_buf
   import xlb_pkg::*;
#(
   parameter int N         = 8,
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 13,
   parameter int ASN_W     = 8,
   parameter int PPN_W     = 20,
   parameter int MODE_W    = 4,
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int IDX_W    = (N > 1) ? $clog2(N) : 1,
   localparam int PA_W     = PPN_W + PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASN_W-1:0]  lk_asn,
   output logic              lk_hit,
   output logic [IDX_W-1:0]  lk_idx,
   output logic              lk_glob,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [MODE_W-1:0] lk_rd_en,
   output logic [MODE_W-1:0] lk_wr_en,
   output logic              lk_rd_trap,
   output logic              lk_wr_trap,
   output logic [PA_W-1:0]   lk_pa,
   input  logic              ins_en,
   input  logic [VPN_W-1:0]  ins_vpn,
   input  logic [ASN_W-1:0]  ins_asn,
   input  logic              ins_glob,
   input  logic [PPN_W-1:0]  ins_ppn,
   input  logic [MODE_W-1:0] ins_rd_en,
   input  logic [MODE_W-1:0] ins_wr_en,
   input  logic              ins_rd_trap,
   input  logic              ins_wr_trap,
   input  logic              rd_adv,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [VPN_W-1:0]  rd_vpn,
   output logic [ASN_W-1:0]  rd_asn,
   output logic              rd_glob,
   output logic [PPN_W-1:0]  rd_ppn,
   output logic [MODE_W-1:0] rd_rd_en,
   output logic [MODE_W-1:0] rd_wr_en,
   output logic              rd_rd_trap,
   output logic              rd_wr_trap,
   input  logic              fl_all,
   input  logic              fl_proc,
   input  logic              fl_addr,
   input  logic [VPN_W-1:0]  fl_vpn,
   input  logic [ASN_W-1:0]  fl_asn
);
   // Elaboration-time parameter checks.
   if (N < 2) begin : g_bad_n
      $error("asn_xlate_buf: N must be at least 2");
   end
   if (PAGE_BITS < 1 || PAGE_BITS >= VA_W) begin : g_bad_page
      $error("asn_xlate_buf: PAGE_BITS must lie inside VA_W");
   end
   if (MODE_W < 1 || ASN_W < 1 || PPN_W < 1) begin : g_bad_w
      $error("asn_xlate_buf: field widths must be positive");
   end

   // Slot storage.
   logic [N-1:0]             valid_q;
   logic [N-1:0]             glob_q;
   logic [N-1:0]             rtrap_q;
   logic [N-1:0]             wtrap_q;
   logic [N-1:0][VPN_W-1:0]  tag_q;
   logic [N-1:0][ASN_W-1:0]  asn_q;
   logic [N-1:0][PPN_W-1:0]  ppn_q;
   logic [N-1:0][MODE_W-1:0] rden_q;
   logic [N-1:0][MODE_W-1:0] wren_q;

   logic [IDX_W-1:0] ptr;
   xlb_flush_e       fop;
   logic             ins_go;
   logic [VPN_W-1:0] lk_vpn;
   logic [N-1:0]     lk_match;
   logic [N-1:0]     fa_match;
   logic [IDX_W-1:0] hit_idx;
   logic             hit;

   assign fop    = xlb_flush_pick(fl_all, fl_proc, fl_addr);
   assign ins_go = ins_en && (fop == FL_NONE);
   assign lk_vpn = lk_va[VA_W-1:PAGE_BITS];

   // Lookup compare and select.
   xlb_match #(.N(N), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
      .valid (valid_q),
      .glob  (glob_q),
      .tag   (tag_q),
      .asn   (asn_q),
      .q_vpn (lk_vpn),
      .q_asn (lk_asn),
      .match (lk_match)
   );

   xlb_prio #(.N(N), .IDX_W(IDX_W)) u_lk_prio (
      .req   (lk_match),
      .found (hit),
      .idx   (hit_idx)
   );

   // Second compare bank for single-page invalidation.
   xlb_match #(.N(N), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fa_match (
      .valid (valid_q),
      .glob  (glob_q),
      .tag   (tag_q),
      .asn   (asn_q),
      .q_vpn (fl_vpn),
      .q_asn (fl_asn),
      .match (fa_match)
   );

   xlb_rr_ptr #(.N(N), .IDX_W(IDX_W)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (fop == FL_ALL),
      .step  (ins_go | rd_adv),
      .ptr   (ptr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         glob_q  <= '0;
         rtrap_q <= '0;
         wtrap_q <= '0;
         tag_q   <= '0;
         asn_q   <= '0;
         ppn_q   <= '0;
         rden_q  <= '0;
         wren_q  <= '0;
      end else begin
         unique case (fop)
            FL_ALL: begin
               valid_q <= '0;
               glob_q  <= '0;
               rtrap_q <= '0;
               wtrap_q <= '0;
               tag_q   <= '0;
               asn_q   <= '0;
               ppn_q   <= '0;
               rden_q  <= '0;
               wren_q  <= '0;
            end
            FL_PROC: valid_q <= valid_q & glob_q;
            FL_ADDR: valid_q <= valid_q & ~fa_match;
            default: begin
               if (ins_go) begin
                  valid_q[ptr] <= 1'b1;
                  glob_q[ptr]  <= ins_glob;
                  rtrap_q[ptr] <= ins_rd_trap;
                  wtrap_q[ptr] <= ins_wr_trap;
                  tag_q[ptr]   <= ins_vpn;
                  asn_q[ptr]   <= ins_asn;
                  ppn_q[ptr]   <= ins_ppn;
                  rden_q[ptr]  <= ins_rd_en;
                  wren_q[ptr]  <= ins_wr_en;
               end
            end
         endcase
      end
   end

   // Lookup result, forced to zero on a miss.
   assign lk_hit     = hit;
   assign lk_idx     = hit ? hit_idx : '0;
   assign lk_glob    = hit & glob_q[hit_idx];
   assign lk_ppn     = hit ? ppn_q[hit_idx] : '0;
   assign lk_rd_en   = hit ? rden_q[hit_idx] : '0;
   assign lk_wr_en   = hit ? wren_q[hit_idx] : '0;
   assign lk_rd_trap = hit & rtrap_q[hit_idx];
   assign lk_wr_trap = hit & wtrap_q[hit_idx];
   assign lk_pa      = hit ? {ppn_q[hit_idx], lk_va[PAGE_BITS-1:0]} : '0;

   // Indexed readback of the slot at the pointer.
   assign rd_idx     = ptr;
   assign rd_valid   = valid_q[ptr];
   assign rd_vpn     = tag_q[ptr];
   assign rd_asn     = asn_q[ptr];
   assign rd_glob    = glob_q[ptr];
   assign rd_ppn     = ppn_q[ptr];
   assign rd_rd_en   = rden_q[ptr];
   assign rd_wr_en   = wren_q[ptr];
   assign rd_rd_trap = rtrap_q[ptr];
   assign rd_wr_trap = wtrap_q[ptr];
endmodule

// File: rtl/xlb_checker.sv
module xlb_checker #(
   parameter int N     = 8,
   parameter int IDX_W = 3,
   parameter int PPN_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fl_all,
   input logic             fl_proc,
   input logic             fl_addr,
   input logic             ins_en,
   input logic             rd_adv,
   input logic [IDX_W-1:0] rd_idx,
   input logic             lk_hit,
   input logic [IDX_W-1:0] lk_idx,
   input logic [PPN_W-1:0] lk_ppn,
   input logic [N-1:0]     valid_q,
   input logic [N-1:0]     glob_q
);
   logic ins_ok;
   assign ins_ok = ins_en & ~fl_all & ~fl_proc & ~fl_addr;

   // R11: a miss drives zero index and page.
   p_miss_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_idx == '0 && lk_ppn == '0));

   // R1: a hit points at a valid slot.
   p_hit_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> valid_q[lk_idx]);

   // R4: flush-all empties storage and rewinds the pointer.
   p_wipe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fl_all |=> (valid_q == '0 && rd_idx == '0));

   // R5: no non-global slot survives a process flush.
   p_proc_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_proc && !fl_all) |=> ((valid_q & ~glob_q) == '0));

   // R5: global slots survive a process flush.
   p_proc_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_proc && !fl_all) |=> ((valid_q & glob_q) == ($past(valid_q) & $past(glob_q))));

   // R2: the slot at the pointer becomes valid after an unblocked insert.
   p_ins_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ins_ok |=> valid_q[$past(rd_idx)]);

   // R3: single step with wrap.
   p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_all && (ins_ok || rd_adv)) |=>
         (rd_idx == (($past(rd_idx) == IDX_W'(N - 1)) ? '0 : $past(rd_idx) + 1'b1)));

   // R7: pointer holds when nothing steps it.
   p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_all && !ins_ok && !rd_adv) |=> $stable(rd_idx));

   // R9: a flush-blocked insert does not move the pointer.
   p_ins_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && !fl_all && (fl_proc || fl_addr) && !rd_adv) |=> $stable(rd_idx));
endmodule

bind asn_xlate_buf xlb_checker #(.N(N), .IDX_W(IDX_W), .PPN_W(PPN_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .fl_all  (fl_all),
   .fl_proc (fl_proc),
   .fl_addr (fl_addr),
   .ins_en  (ins_en),
   .rd_adv  (rd_adv),
   .rd_idx  (rd_idx),
   .lk_hit  (lk_hit),
   .lk_idx  (lk_idx),
   .lk_ppn  (lk_ppn),
   .valid_q (valid_q),
   .glob_q  (glob_q)
);

// File: tb/asn_xlate_buf_test.sv
module asn_xlate_buf_test;
   localparam int N = 8, VA_W = 32, PB = 13, ASN_W = 8, PPN_W = 20, MW = 4;
   localparam int VPN_W = VA_W - PB, IDX_W = 3, PA_W = PPN_W + PB;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [VA_W-1:0] lk_va = '0;
   logic [ASN_W-1:0] lk_asn = '0;
   logic lk_hit, lk_glob, lk_rd_trap, lk_wr_trap;
   logic [IDX_W-1:0] lk_idx;
   logic [PPN_W-1:0] lk_ppn;
   logic [MW-1:0] lk_rd_en, lk_wr_en;
   logic [PA_W-1:0] lk_pa;
   logic ins_en = 0, ins_glob = 0, ins_rd_trap = 0, ins_wr_trap = 0;
   logic [VPN_W-1:0] ins_vpn = '0;
   logic [ASN_W-1:0] ins_asn = '0;
   logic [PPN_W-1:0] ins_ppn = '0;
   logic [MW-1:0] ins_rd_en = '0, ins_wr_en = '0;
   logic rd_adv = 0;
   logic [IDX_W-1:0] rd_idx;
   logic rd_valid, rd_glob, rd_rd_trap, rd_wr_trap;
   logic [VPN_W-1:0] rd_vpn;
   logic [ASN_W-1:0] rd_asn;
   logic [PPN_W-1:0] rd_ppn;
   logic [MW-1:0] rd_rd_en, rd_wr_en;
   logic fl_all = 0, fl_proc = 0, fl_addr = 0;
   logic [VPN_W-1:0] fl_vpn = '0;
   logic [ASN_W-1:0] fl_asn = '0;

   asn_xlate_buf uut (.*);

   always #4 clk = ~clk;  // 125 MHz

   // Reference model.
   logic m_valid [N], m_glob [N], m_rt [N], m_wt [N];
   logic [VPN_W-1:0] m_vpn [N];
   logic [ASN_W-1:0] m_asn [N];
   logic [PPN_W-1:0] m_ppn [N];
   logic [MW-1:0] m_re [N], m_we [N];
   int m_ptr = 0;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int m_find(logic [VPN_W-1:0] v, logic [ASN_W-1:0] a);
      for (int i = 0; i < N; i++)
         if (m_valid[i] && m_vpn[i] == v && (m_glob[i] || m_asn[i] == a)) return i;
      return -1;
   endfunction

   function automatic bit m_conflict(logic [VPN_W-1:0] v, logic [ASN_W-1:0] a, logic g);
      for (int i = 0; i < N; i++)
         if (m_valid[i] && m_vpn[i] == v && (m_glob[i] || g || m_asn[i] == a)) return 1;
      return 0;
   endfunction

   task automatic m_clear();
      for (int i = 0; i < N; i++) begin
         m_valid[i] = 0; m_glob[i] = 0; m_rt[i] = 0; m_wt[i] = 0;
         m_vpn[i] = '0; m_asn[i] = '0; m_ppn[i] = '0; m_re[i] = '0; m_we[i] = '0;
      end
      m_ptr = 0;
   endtask

   task automatic m_update();
      bit ins_ok;
      ins_ok = ins_en && !fl_all && !fl_proc && !fl_addr;
      if (fl_all) m_clear();
      else begin
         if (fl_proc) begin
            for (int i = 0; i < N; i++) if (!m_glob[i]) m_valid[i] = 0;
         end else if (fl_addr) begin
            for (int i = 0; i < N; i++)
               if (m_vpn[i] == fl_vpn && (m_glob[i] || m_asn[i] == fl_asn)) m_valid[i] = 0;
         end else if (ins_en) begin
            m_valid[m_ptr] = 1; m_glob[m_ptr] = ins_glob; m_rt[m_ptr] = ins_rd_trap;
            m_wt[m_ptr] = ins_wr_trap; m_vpn[m_ptr] = ins_vpn; m_asn[m_ptr] = ins_asn;
            m_ppn[m_ptr] = ins_ppn; m_re[m_ptr] = ins_rd_en; m_we[m_ptr] = ins_wr_en;
         end
         if (ins_ok || rd_adv) m_ptr = (m_ptr + 1) % N;
      end
   endtask

   task automatic check_outputs();
      int e;
      e = m_find(lk_va[VA_W-1:PB], lk_asn);
      chk("R1 hit", 64'(lk_hit), 64'(e >= 0));
      if (e >= 0) begin
         chk("R1 idx", 64'(lk_idx), 64'(e));
         chk("R11 fields", 64'({lk_ppn, lk_rd_en, lk_wr_en, lk_rd_trap, lk_wr_trap, lk_glob}),
             64'({m_ppn[e], m_re[e], m_we[e], m_rt[e], m_wt[e], m_glob[e]}));
         chk("R8 pa", 64'(lk_pa), 64'({m_ppn[e], lk_va[PB-1:0]}));
      end else begin
         chk("R11 miss zero", 64'({lk_idx, lk_ppn, lk_rd_en, lk_wr_en, lk_rd_trap, lk_wr_trap, lk_glob, lk_pa}), 64'd0);
      end
      chk("R3 ptr", 64'(rd_idx), 64'(m_ptr));
      chk("R7 readback", {6'd0, rd_valid, rd_vpn, rd_asn, rd_glob, rd_ppn, rd_rd_en, rd_wr_en, rd_rd_trap, rd_wr_trap},
          {6'd0, m_valid[m_ptr], m_vpn[m_ptr], m_asn[m_ptr], m_glob[m_ptr], m_ppn[m_ptr],
           m_re[m_ptr], m_we[m_ptr], m_rt[m_ptr], m_wt[m_ptr]});
   endtask

   // Inputs are set after a falling edge; this checks, clocks, updates the model.
   task automatic do_cycle();
      #1 check_outputs();
      @(posedge clk);
      m_update();
      @(negedge clk);
      ins_en = 0; rd_adv = 0; fl_all = 0; fl_proc = 0; fl_addr = 0;
   endtask

   task automatic set_lk(int v, int a);
      lk_va = {VPN_W'(v), PB'($urandom)};
      lk_asn = ASN_W'(a);
   endtask

   task automatic look(int v, int a, bit exp_hit, int exp_idx, string req);
      set_lk(v, a);
      #1;
      chk(req, 64'(lk_hit), 64'(exp_hit));
      if (exp_hit) chk(req, 64'(lk_idx), 64'(exp_idx));
      @(negedge clk);
   endtask

   task automatic put(int v, int a, bit g, int p);
      ins_en = 1; ins_vpn = VPN_W'(v); ins_asn = ASN_W'(a); ins_glob = g;
      ins_ppn = PPN_W'(p); ins_rd_en = MW'($urandom); ins_wr_en = MW'($urandom);
      ins_rd_trap = 1'($urandom); ins_wr_trap = 1'($urandom);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int seed_v;
      seed_v = $urandom(32'd20240611);
      m_clear();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R10: reset state
      set_lk(0, 0);
      #1;
      chk("R10 valid", 64'(rd_valid), 64'd0);
      chk("R10 ptr", 64'(rd_idx), 64'd0);
      chk("R10 miss", 64'(lk_hit), 64'd0);
      @(negedge clk);

      // R2/R3: fill all slots, slot 2 global
      for (int i = 0; i < N; i++) begin
         put(i + 1, 1, i == 2, 100 + i);
         do_cycle();
         look(i + 1, 1, 1, i, "R2 slot");
      end
      chk("R3 wrap", 64'(rd_idx), 64'd0);

      // R1: global vs identifier mismatch
      look(3, 5, 1, 2, "R1 global");
      look(1, 5, 0, 0, "R1 asn mismatch");

      // R6: wrong identifier keeps slot, right one drops it
      fl_addr = 1; fl_vpn = 1; fl_asn = 2; do_cycle();
      look(1, 1, 1, 0, "R6 keep");
      fl_addr = 1; fl_vpn = 1; fl_asn = 1; do_cycle();
      look(1, 1, 0, 0, "R6 drop");

      // R9: insert blocked by a flush; same-cycle lookup sees old state
      set_lk(2, 1);
      put(20, 1, 0, 7);
      fl_addr = 1; fl_vpn = 2; fl_asn = 1;
      #1 chk("R9 pre-flush hit", 64'(lk_hit), 64'd1);
      do_cycle();
      look(20, 1, 0, 0, "R9 no insert");
      look(2, 1, 0, 0, "R9 flushed");
      chk("R9 ptr", 64'(rd_idx), 64'd0);

      // R3: insert together with rd_adv steps once
      put(30, 3, 0, 9); rd_adv = 1; do_cycle();
      chk("R3 single step", 64'(rd_idx), 64'd1);

      // R7: advance alone, then hold
      rd_adv = 1; do_cycle();
      chk("R7 adv", 64'(rd_idx), 64'd2);
      do_cycle();
      chk("R7 hold", 64'(rd_idx), 64'd2);

      // R5: process flush keeps global slot only
      fl_proc = 1; do_cycle();
      look(3, 9, 1, 2, "R5 global kept");
      look(4, 1, 0, 0, "R5 local dropped");

      // R12 / R4: flush-all wins over flush-proc
      rd_adv = 1; do_cycle();
      fl_all = 1; fl_proc = 1; do_cycle();
      chk("R12 ptr", 64'(rd_idx), 64'd0);
      look(3, 9, 0, 0, "R4 wiped");
      chk("R4 readback", 64'({rd_valid, rd_ppn, rd_vpn}), 64'd0);

      // Random traffic
      for (int c = 0; c < 4000; c++) begin
         int r, v, a;
         bit g;
         if ($urandom_range(1, 0) == 1) begin
            int k = $urandom_range(N - 1, 0);
            set_lk(m_vpn[k], $urandom_range(3, 0) == 0 ? $urandom_range(3, 0) : m_asn[k]);
         end else set_lk($urandom_range(15, 0), $urandom_range(3, 0));
         r = $urandom_range(99, 0);
         v = $urandom_range(15, 0);
         a = $urandom_range(3, 0);
         g = ($urandom_range(7, 0) == 0);
         if (r < 45) begin
            if (!m_conflict(VPN_W'(v), ASN_W'(a), g)) put(v, a, g, $urandom);
            if (r < 3) begin fl_addr = 1; fl_vpn = VPN_W'($urandom_range(15, 0)); fl_asn = ASN_W'(a); end
         end else if (r < 52) begin
            fl_addr = 1; fl_vpn = VPN_W'(v); fl_asn = ASN_W'(a);
         end else if (r < 54) fl_proc = 1;
         else if (r == 54) fl_all = 1;
         else if (r < 66) rd_adv = 1;
         if (r % 9 == 0) rd_adv = 1;
         do_cycle();
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule